// File: doc/BRIEF.md
# Page Write Collector with Programming Status

This block sits between a host bus and a nonvolatile memory array. The host issues byte writes, and the block gathers them into a page buffer. A load-window timer starts again on every accepted write. When the host stops writing for the length of that window, the block hands the whole page to the array as one commit request. The request carries a valid bit for each byte, so only the bytes the host wrote are programmed. The block then holds the array busy for an internally timed programming interval.

While a page is being loaded or programmed, a read returns a status byte instead of array data. Bit 7 is the complement of bit 7 of the last byte written. Bit 6 flips on every status read. Bit 5 goes high once the load window has closed and programming has begun. A separate ready flag is low for the whole programming interval. When programming ends, reads return array contents again, so the polled bits reflect the real data.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `cmt_req` is 0, `cmt_mask` is all zeros and `rd_data` is 0.
- R2: Write address bits [12:6] give the page and bits [5:0] give the byte slot. An accepted byte is stored in that slot, and bit [5:0] of `cmt_mask` is set for it. A later write to the same slot replaces the earlier byte.
- R3: Programming starts (`cmt_req` rises, `ready` falls) exactly LOAD_TIMEOUT clock edges after the last accepted write. Each accepted write restarts this count.
- R4: While a page is loading, a write whose bits [12:6] differ from the loading page is dropped. It stores nothing and does not restart the load count.
- R5: Writes that arrive during programming are ignored. `cmt_mask` and the committed data stay unchanged.
- R6: Once started, programming lasts PROG_CYCLES clocks if `cmt_done` has been seen by then. Otherwise it lasts until the edge at which `cmt_done` is sampled high. `cmt_req` stays high and `ready` stays low for the whole interval.
- R7: A read taken while a page is loading or programming returns a status byte. Bit 7 is the complement of bit 7 of the last accepted write. Bit 6 is 0 on the first status read after a load begins and flips on each further status read. Bit 5 is 0 during loading and 1 during programming. Bits 4..0 are 0.
- R8: A read taken while idle returns `arr_rd_data` one clock later. `arr_rd_addr` follows `rd_addr`.
- R9: `cmt_mask` holds exactly the slots loaded in the current page. It is all zeros after programming ends, so committed array contents read back through R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_addr | input | 13 | Write address: page in [12:6], slot in [5:0] |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 13 | Read address |
| arr_rd_addr | output | 13 | Address presented to the array for reads |
| arr_rd_data | input | 8 | Array byte at `arr_rd_addr` |
| rd_data | output | 8 | Registered read result, array data or status |
| ready | output | 1 | Low while programming runs |
| cmt_req | output | 1 | Commit request, held for the programming interval |
| cmt_page | output | 7 | Page being committed |
| cmt_data | output | 512 | Page buffer, slot n in bits [8n+7:8n] |
| cmt_mask | output | 64 | Per-slot valid bits |
| cmt_done | input | 1 | Array signals the page is programmed |

## Verification
The checker assumes the array raises `cmt_done` only while `cmt_req` is high, and at most once per commit. It also assumes reads and writes are single-cycle strobes. Some checks treat a status read and a phase change on the same edge as distinct cases, so the bench never places a read on the edge where the load window expires or programming ends. Its array model pulses `cmt_done` once, at a chosen cycle inside the request.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_t;

  // Status byte: polled complement, toggle, window-closed flag, zero fill.
  function automatic logic [BYTE_W-1:0] status_byte(input logic last_msb,
                                                     input logic tog,
                                                     input logic started);
    status_byte = {~last_msb, tog, started, 5'b00000};
  endfunction
endpackage

// File: rtl/pgwr_cnt.sv
module pgwr_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (en)       cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
  parameter int SLOTS = 64,
  parameter int DW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_stb,
  input  logic [$clog2(SLOTS)-1:0]  wr_slot,
  input  logic [DW-1:0]             wr_data,
  input  logic                      clr,
  output logic [SLOTS*DW-1:0]       data_flat,
  output logic [SLOTS-1:0]          mask
);
  localparam int SW = $clog2(SLOTS);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DW-1:0] byte_q;
    logic          vld_q;
    logic          hit;

    assign hit = wr_stb && (wr_slot == SW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr) begin
        vld_q  <= 1'b0;
      end else if (hit) begin
        byte_q <= wr_data;
        vld_q  <= 1'b1;
      end
    end

    assign data_flat[g*DW +: DW] = byte_q;
    assign mask[g]               = vld_q;
  end
endmodule

// File: rtl/pgwr_stat.sv
module pgwr_stat
  import pgwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  phase_t            phase,
  input  logic              load_start,
  input  logic              last_msb,
  input  logic [BYTE_W-1:0] arr_rd_data,
  output logic              status_rd,
  output logic [BYTE_W-1:0] rd_data
);
  logic tog_q;

  assign status_rd = rd_en && (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (load_start)     tog_q <= 1'b0;
      else if (status_rd) tog_q <= ~tog_q;
      if (status_rd)
        rd_data <= status_byte(last_msb, tog_q, phase == PH_PROG);
      else if (rd_en)
        rd_data <= arr_rd_data;
    end
  end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int PAGE_BYTES   = 64,
  parameter int LOAD_TIMEOUT = 20,
  parameter int PROG_CYCLES  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [7:0]                     wr_data,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [ADDR_W-1:0]              arr_rd_addr,
  input  logic [7:0]                     arr_rd_data,
  output logic [7:0]                     rd_data,
  output logic                           ready,
  output logic                           cmt_req,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] cmt_page,
  output logic [PAGE_BYTES*8-1:0]        cmt_data,
  output logic [PAGE_BYTES-1:0]          cmt_mask,
  input  logic                           cmt_done
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    page_of = a[ADDR_W-1:SLOT_W];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    slot_of = a[SLOT_W-1:0];
  endfunction

  phase_t            phase_q;
  logic [PAGE_W-1:0] page_q;
  logic              last_msb_q;
  logic              done_seen_q;

  // Named internal events
  logic wr_accept, load_start, load_expire, prog_end, status_rd;
  logic tmr_hit, prog_hit;

  assign load_start  = wr_en && (phase_q == PH_IDLE);
  assign wr_accept   = load_start ||
                       (wr_en && (phase_q == PH_LOAD) && (page_of(wr_addr) == page_q));
  assign load_expire = (phase_q == PH_LOAD) && !wr_accept && tmr_hit;
  assign prog_end    = (phase_q == PH_PROG) && prog_hit && (done_seen_q || cmt_done);

  pgwr_cnt #(.LIMIT(LOAD_TIMEOUT)) u_load_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (wr_accept || (phase_q != PH_LOAD)),
    .en   (1'b1),
    .hit  (tmr_hit)
  );

  pgwr_cnt #(.LIMIT(PROG_CYCLES)) u_prog_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (phase_q != PH_PROG),
    .en   (!prog_hit),
    .hit  (prog_hit)
  );

  pgwr_buf #(.SLOTS(PAGE_BYTES), .DW(8)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_accept),
    .wr_slot  (slot_of(wr_addr)),
    .wr_data  (wr_data),
    .clr      (prog_end),
    .data_flat(cmt_data),
    .mask     (cmt_mask)
  );

  pgwr_stat u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .phase      (phase_q),
    .load_start (load_start),
    .last_msb   (last_msb_q),
    .arr_rd_data(arr_rd_data),
    .status_rd  (status_rd),
    .rd_data    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      page_q      <= '0;
      last_msb_q  <= 1'b0;
      done_seen_q <= 1'b0;
    end else begin
      if (wr_accept) last_msb_q <= wr_data[7];
      unique case (phase_q)
        PH_IDLE: if (load_start) begin
          phase_q <= PH_LOAD;
          page_q  <= page_of(wr_addr);
        end
        PH_LOAD: if (load_expire) begin
          phase_q     <= PH_PROG;
          done_seen_q <= 1'b0;
        end
        PH_PROG: begin
          if (cmt_done) done_seen_q <= 1'b1;
          if (prog_end) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign arr_rd_addr = rd_addr;
  assign cmt_req     = (phase_q == PH_PROG);
  assign ready       = (phase_q != PH_PROG);
  assign cmt_page    = page_q;
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int PAGE_BYTES = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ready,
  input logic                  cmt_req,
  input logic [PAGE_BYTES-1:0] cmt_mask,
  input logic [7:0]            rd_data,
  input logic                  wr_accept,
  input logic                  load_expire,
  input logic                  prog_end,
  input logic                  status_rd
);
  AST_REQ_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmt_req) |-> $past(load_expire)); // R3

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_req |-> !wr_accept); // R5

  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_req && $past(cmt_req)) |-> $stable(cmt_mask)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_req && !prog_end) |=> cmt_req); // R6

  AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_req |-> !ready); // R6

  AST_STATUS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (rd_data[4:0] == 5'b0)); // R7

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    prog_end |=> (cmt_mask == '0)); // R9
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.PAGE_BYTES(PAGE_BYTES)) u_pgwr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .cmt_req    (cmt_req),
  .cmt_mask   (cmt_mask),
  .rd_data    (rd_data),
  .wr_accept  (wr_accept),
  .load_expire(load_expire),
  .prog_end   (prog_end),
  .status_rd  (status_rd)
);

// File: tb/test_pgwr_ctrl.sv
`timescale 1ns/1ps
module test_pgwr_ctrl;
  localparam int T = 20;
  localparam int P = 16;

  typedef struct packed {
    logic [12:0] a;
    logic [7:0]  d;
  } wvec_t;

  // Page 3 load; slot 5 is written twice.
  localparam wvec_t VEC [6] = '{
    '{13'h0C0, 8'hA5}, '{13'h0FF, 8'h3C}, '{13'h0C5, 8'h11},
    '{13'h0C5, 8'h92}, '{13'h0D0, 8'h7E}, '{13'h0E1, 8'hC8}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0, cmt_done = 1'b0;
  logic [12:0]  wr_addr = '0, rd_addr = '0, arr_rd_addr;
  logic [7:0]   wr_data = '0, arr_rd_data, rd_data;
  logic         ready, cmt_req;
  logic [6:0]   cmt_page;
  logic [511:0] cmt_data;
  logic [63:0]  cmt_mask;
  logic [7:0]   mem [512];

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  assign arr_rd_data = mem[arr_rd_addr[8:0]];

  pgwr_ctrl #(.LOAD_TIMEOUT(T), .PROG_CYCLES(P)) i_pgwr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .arr_rd_addr(arr_rd_addr),
    .arr_rd_data(arr_rd_data), .rd_data(rd_data), .ready(ready), .cmt_req(cmt_req),
    .cmt_page(cmt_page), .cmt_data(cmt_data), .cmt_mask(cmt_mask), .cmt_done(cmt_done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [12:0] a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
    v = rd_data;
  endtask

  // Drives the array side of a commit; poke adds a write and status reads.
  task automatic run_prog(input int dly, input bit poke, input logic [63:0] exp_mask,
                          output int dur);
    int cnt = 0;
    while (!ready && cnt < 1000) begin
      cmt_done = (cnt == dly);
      if (cmt_done)
        for (int i = 0; i < 64; i++)
          if (cmt_mask[i]) mem[{cmt_page[2:0], 6'(i)}] = cmt_data[i*8 +: 8];
      wr_en = poke && (cnt == 1); wr_addr = 13'h0C1; wr_data = 8'h55;
      rd_en = poke && (cnt == 4 || cnt == 5); rd_addr = 13'h0C0;
      tick();
      cnt++;
      if (poke && cnt == 3) chk(cmt_mask == exp_mask, "R5 mask after busy write", cmt_mask, exp_mask);
      if (poke && cnt == 5) chk(rd_data == 8'h20, "R7 prog status 1", rd_data, 8'h20);
      if (poke && cnt == 6) chk(rd_data == 8'h60, "R7 prog status 2", rd_data, 8'h60);
    end
    cmt_done = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    dur = cnt;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [63:0] emask;
    logic [7:0]  edat;
    int          dur;

    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    repeat (3) tick();
    rst_n = 1'b1;

    // R1 reset state
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(cmt_req == 1'b0, "R1 cmt_req", cmt_req, 0);
    chk(cmt_mask == '0, "R1 mask", cmt_mask, 0);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);

    // Table-driven page load (R2, R3, R7, R5, R6, R9, R8)
    emask = '0;
    for (int i = 0; i < 6; i++) begin
      do_write(VEC[i].a, VEC[i].d);
      emask[VEC[i].a[5:0]] = 1'b1;
      if (i != 5) repeat (2) tick();
    end
    do_read(13'h0C0, v);
    chk(v == 8'h00, "R7 load status 1", v, 8'h00);
    do_read(13'h0C0, v);
    chk(v == 8'h40, "R7 load status 2", v, 8'h40);
    repeat (T - 3) tick();
    chk(ready == 1'b1, "R3 still loading", ready, 1);
    tick();
    chk(ready == 1'b0 && cmt_req == 1'b1, "R3 start after window", {ready, cmt_req}, 2'b01);
    chk(cmt_mask == emask, "R2 mask slots", cmt_mask, emask);
    chk(cmt_page == 7'd3, "R2 page", cmt_page, 3);
    run_prog(3, 1'b1, emask, dur);
    chk(dur == P, "R6 min duration", dur, P);
    chk(cmt_mask == '0 && cmt_req == 1'b0, "R9 mask cleared", cmt_mask, 0);
    for (int i = 0; i < 6; i++) begin
      edat = VEC[i].d;
      for (int j = i + 1; j < 6; j++) if (VEC[j].a == VEC[i].a) edat = VEC[j].d;
      do_read(VEC[i].a, v);
      chk(v == edat, "R8 R2 readback", v, edat);
    end
    do_read(13'h0C1, v);
    chk(v == 8'hFF, "R5 busy write ignored", v, 8'hFF);

    // Other-page write dropped, late done (R4, R6)
    do_write(13'h040, 8'h80);
    repeat (4) tick();
    do_write(13'h081, 8'h33);
    repeat (T - 6) tick();
    chk(ready == 1'b1, "R4 no restart, still loading", ready, 1);
    tick();
    chk(ready == 1'b0, "R4 no restart, started", ready, 0);
    chk(cmt_mask == 64'h1, "R4 mask one slot", cmt_mask, 1);
    run_prog(P + 4, 1'b0, 64'h1, dur);
    chk(dur == P + 5, "R6 waits for done", dur, P + 5);
    do_read(13'h040, v);
    chk(v == 8'h80, "R8 page1 data", v, 8'h80);
    do_read(13'h081, v);
    chk(v == 8'hFF, "R4 dropped byte absent", v, 8'hFF);

    // Retrigger (R3)
    do_write(13'h100, 8'h01);
    repeat (T - 2) tick();
    do_write(13'h101, 8'h02);
    repeat (T - 1) tick();
    chk(ready == 1'b1, "R3 window restarted", ready, 1);
    tick();
    chk(ready == 1'b0, "R3 start after restart", ready, 0);
    chk(cmt_mask == 64'h3, "R2 two slots", cmt_mask, 3);
    run_prog(0, 1'b0, 64'h3, dur);
    chk(dur == P, "R6 early done", dur, P);
    do_read(13'h101, v);
    chk(v == 8'h02, "R8 retrigger data", v, 8'h02);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule